// File: doc/BRIEF.md
# Run-Time Configurable Serial Transceiver with Parity

A full-duplex asynchronous serial transceiver whose character format and bit rate are chosen by an 8-bit configuration byte that may change while the block runs. A shared oversampling tick (128 ticks per bit at the slowest rate) acts as the clock enable for both directions. Four bit rates are available, with 7 or 8 data bits and odd, even or no parity. A frame is therefore 9, 10 or 11 bits long. With 7 data bits and parity enabled, the parity bit sits in the character's most significant bit position.

The transmit side takes bytes through a valid/ready pair. A byte and the configuration are captured on the cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low for the whole frame, so a producer may hold `tx_valid` and the next byte until it is taken. The line output is open-drain style: `tx_oe` high pulls the line low, and a one is sent by releasing the line.

The receive side delivers each character as a one-cycle `rx_valid` pulse, with the received parity bit and a sticky parity-error flag. There is no back-pressure on receive. The consumer must take `rx_data` in the pulse cycle, although the value is held until the next character arrives. Buffering and flow control belong to neighbouring blocks.

Top module: `cfg_uart`

## Requirements
- R1: After reset `tx_oe`=0, `tx_ready`=1, `rx_valid`=0 and `rx_perr`=0.
- R2: cfg[1:0] selects the bit length: code 0, 1, 2 and 3 give 128, 64, 16 and 8 ticks per bit. `tx_ready` returns exactly frame-length × bit-length ticks after acceptance.
- R3: A frame is sent least significant bit first, in this order: a low start bit, the data bits, an optional parity bit and one high stop bit. Its length is 10 bits, plus 1 when cfg[6] or cfg[7] is set, minus 1 when cfg[5] is set.
- R4: cfg[7]=1 selects odd parity, meaning the data ones plus the parity bit make an odd count. Otherwise cfg[6]=1 selects even parity. When both bits are set, odd parity applies.
- R5: `tx_oe`=1 drives the line low and `tx_oe`=0 releases it. The line is never driven high, and it is released whenever the transmitter is idle.
- R6: A byte is accepted when `tx_valid` and `tx_ready` are both high. `tx_ready` is low from the next cycle until the frame ends. Data and configuration are captured at acceptance, so later changes to `tx_data` do not alter the frame.
- R7: A configuration change during a frame does not affect that frame in either direction. It takes effect at the next frame.
- R8: The receiver detects a low line while idle. It samples the first data bit 1.5 bit periods after detection and each later bit one period after the previous one. It pulses `rx_valid` once per frame after sampling the stop bit.
- R9: The start bit is checked again half a bit period after detection. If the line is high there, the receiver returns to idle and reports nothing.
- R10: With cfg[5]=1 (7 data bits), `rx_data[7]` is 0.
- R11: `rx_par` carries the received parity bit when parity is enabled, and 0 otherwise. A parity mismatch sets `rx_perr`, which stays set until reset.
- R12: While `tick` is low, neither direction advances its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling clock enable, 128 per bit at code 0 |
| cfg | input | 8 | Format: [1:0] rate, [5] 7 data bits, [6] even, [7] odd |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| tx_data | input | 8 | Byte to transmit |
| tx_oe | output | 1 | 1 = pull the line low, 0 = release it |
| rx_pin | input | 1 | Receive line, asynchronous |
| rx_valid | output | 1 | One-cycle pulse when a character is delivered |
| rx_data | output | 8 | Received character |
| rx_par | output | 1 | Received parity bit (0 without parity) |
| rx_perr | output | 1 | Sticky parity error |

## Verification
A wrong bit counter or wrong latched format shows at the ports within one frame. The transmitted bit sequence differs at the centre sample of the affected bit, and `tx_ready` returns a whole number of bit periods early or late. A wrong receive shift alignment or parity sense shows as a wrong `rx_data`, `rx_par` or `rx_perr` on the `rx_valid` pulse that ends the same frame. A missing glitch filter or a counter that runs without `tick` produces an extra `rx_valid` pulse, or a frame end that is off, within a few bit periods.

// File: rtl/cfg_uart_pkg.sv
package cfg_uart_pkg;

  typedef struct packed {
    logic       par_en;
    logic       par_odd;
    logic       seven;
    logic [1:0] baud;
  } fmt_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_st_t;

  // ticks per bit for a rate code; base is the code-0 length
  function automatic int unsigned bit_ticks(input logic [1:0] b, input int unsigned base);
    case (b)
      2'd0:    return base;
      2'd1:    return base / 2;
      2'd2:    return base / 8;
      default: return base / 16;
    endcase
  endfunction

  // total bits on the wire, start and stop included
  function automatic logic [3:0] frame_bits(input logic par_en, input logic seven);
    return 4'd9 + {3'b000, par_en} + {3'b000, ~seven};
  endfunction

  // parity bit to send for the given sense
  function automatic logic par_calc(input logic [7:0] d, input logic seven, input logic odd);
    logic p;
    p = seven ? ^d[6:0] : ^d;
    return p ^ odd;
  endfunction

endpackage

// File: rtl/cfg_uart_sync.sv
module cfg_uart_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx
  import cfg_uart_pkg::*;
#(
  parameter int unsigned BASE_DIV = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  fmt_t       fmt_in,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       tx_oe
);
  localparam int CNT_W = $clog2(BASE_DIV + 1);

  logic             busy;
  logic [10:0]      sh;
  logic [3:0]       left;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       baud_l;
  logic [10:0]      frm;

  // frame image, LSB is the first bit on the wire; unused top bits stay 1 (stop/idle)
  always_comb begin
    frm    = '1;
    frm[0] = 1'b0;
    if (fmt_in.seven) begin
      frm[7:1] = tx_data[6:0];
      if (fmt_in.par_en) frm[8] = par_calc(tx_data, 1'b1, fmt_in.par_odd);
    end else begin
      frm[8:1] = tx_data;
      if (fmt_in.par_en) frm[9] = par_calc(tx_data, 1'b0, fmt_in.par_odd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sh     <= '1;
      left   <= '0;
      cnt    <= '0;
      baud_l <= '0;
    end else if (!busy) begin
      if (tx_valid) begin
        busy   <= 1'b1;
        sh     <= frm;
        left   <= frame_bits(fmt_in.par_en, fmt_in.seven);
        cnt    <= CNT_W'(bit_ticks(fmt_in.baud, BASE_DIV));
        baud_l <= fmt_in.baud;
      end
    end else if (tick) begin
      if (cnt == CNT_W'(1)) begin
        cnt  <= CNT_W'(bit_ticks(baud_l, BASE_DIV));
        sh   <= {1'b1, sh[10:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign tx_ready = ~busy;
  assign tx_oe    = busy & ~sh[0];

  a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> tx_oe);
  a_r3_stop_released: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left == 4'd1) |-> !tx_oe);
  a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> ($stable(sh) && $stable(cnt) && busy));
endmodule

// File: rtl/cfg_uart_rx.sv
module cfg_uart_rx
  import cfg_uart_pkg::*;
#(
  parameter int unsigned BASE_DIV = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  fmt_t       fmt_in,
  input  logic       rx_s,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_par,
  output logic       rx_perr
);
  localparam int CNT_W = $clog2(BASE_DIV + 1);

  rx_st_t           st;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       left;
  logic [9:0]       sh;
  fmt_t             f_l;

  logic [9:0] nxt_sh;
  logic [3:0] off;
  logic [3:0] pidx;
  logic [7:0] data8;
  logic       pbit;
  logic [CNT_W-1:0] per_l;

  // samples arrive at the top; after the last one the frame sits right-aligned at off
  always_comb begin
    nxt_sh = {rx_s, sh[9:1]};
    off    = 4'd11 - frame_bits(f_l.par_en, f_l.seven);
    pidx   = off + (f_l.seven ? 4'd7 : 4'd8);
    data8  = nxt_sh[off +: 8];
    if (f_l.seven) data8[7] = 1'b0;
    pbit   = nxt_sh[pidx];
    per_l  = CNT_W'(bit_ticks(f_l.baud, BASE_DIV));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      left     <= '0;
      sh       <= '0;
      f_l      <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_par   <= 1'b0;
      rx_perr  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        RX_IDLE: if (tick && !rx_s) begin
          st   <= RX_START;
          f_l  <= fmt_in;
          cnt  <= CNT_W'(bit_ticks(fmt_in.baud, BASE_DIV) / 2);
          left <= frame_bits(fmt_in.par_en, fmt_in.seven) - 4'd1;
        end
        RX_START: if (tick) begin
          if (cnt == CNT_W'(1)) begin
            if (rx_s) st <= RX_IDLE;
            else begin
              st  <= RX_DATA;
              cnt <= per_l;
            end
          end else cnt <= cnt - CNT_W'(1);
        end
        default: if (tick) begin
          if (cnt == CNT_W'(1)) begin
            sh   <= nxt_sh;
            left <= left - 4'd1;
            cnt  <= per_l;
            if (left == 4'd1) begin
              st       <= RX_IDLE;
              rx_valid <= 1'b1;
              rx_data  <= data8;
              rx_par   <= f_l.par_en & pbit;
              if (f_l.par_en && (pbit != par_calc(data8, f_l.seven, f_l.par_odd)))
                rx_perr <= 1'b1;
            end
          end else cnt <= cnt - CNT_W'(1);
        end
      endcase
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r11_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
    rx_perr |=> rx_perr);
  a_r9_glitch_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_START && tick && cnt == CNT_W'(1) && rx_s) |=> (st == RX_IDLE && !rx_valid));
  a_r10_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && f_l.seven) |-> !rx_data[7]);
  a_r12_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st != RX_IDLE && !tick) |=> ($stable(cnt) && $stable(st)));
endmodule

// File: rtl/cfg_uart.sv
module cfg_uart
  import cfg_uart_pkg::*;
#(
  parameter int unsigned BASE_DIV    = 128,  // ticks per bit at rate code 0; multiple of 32
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] cfg,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       tx_oe,
  input  logic       rx_pin,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_par,
  output logic       rx_perr
);
  fmt_t fmt;
  logic rx_s;
  logic unused_cfg_bits;

  // odd sense has priority when both parity bits are set
  assign fmt.par_en   = cfg[6] | cfg[7];
  assign fmt.par_odd  = cfg[7];
  assign fmt.seven    = cfg[5];
  assign fmt.baud     = cfg[1:0];
  assign unused_cfg_bits = ^cfg[4:2];

  cfg_uart_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(rx_pin), .q(rx_s)
  );

  cfg_uart_tx #(.BASE_DIV(BASE_DIV)) tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fmt_in(fmt),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_oe(tx_oe)
  );

  cfg_uart_rx #(.BASE_DIV(BASE_DIV)) rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fmt_in(fmt), .rx_s(rx_s),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_par(rx_par), .rx_perr(rx_perr)
  );
endmodule

// File: tb/cfg_uart_tb_top.sv
`timescale 1ns/1ps
module cfg_uart_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [7:0] cfg = 8'h00;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       rx_drv = 1'b1;
  logic       loop = 1'b0;
  logic       tx_ready, tx_oe, rx_valid, rx_par, rx_perr;
  logic [7:0] rx_data;
  logic       rx_pin;

  int total = 0;
  int bad = 0;
  int n_rx = 0;
  logic [7:0] last_d = 8'h00;
  logic       last_p = 1'b0;

  assign rx_pin = loop ? ~tx_oe : rx_drv;

  always #2.5 clk = ~clk;

  cfg_uart dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_oe(tx_oe),
    .rx_pin(rx_pin), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par(rx_par), .rx_perr(rx_perr)
  );

  always @(negedge clk) if (rx_valid) begin
    n_rx   <= n_rx + 1;
    last_d <= rx_data;
    last_p <= rx_par;
  end

  task automatic chk(input logic ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int per_of(input logic [7:0] c);
    case (c[1:0])
      2'd0: return 128;
      2'd1: return 64;
      2'd2: return 16;
      default: return 8;
    endcase
  endfunction

  function automatic int len_of(input logic [7:0] c);
    return 10 + ((c[6] || c[7]) ? 1 : 0) - (c[5] ? 1 : 0);
  endfunction

  function automatic logic par_of(input logic [7:0] d, input logic [7:0] c);
    logic p = 1'b0;
    for (int i = 0; i < (c[5] ? 7 : 8); i++) p = p ^ d[i];
    return c[7] ? ~p : p;
  endfunction

  function automatic logic [10:0] frame_of(input logic [7:0] d, input logic [7:0] c);
    logic [10:0] v = '1;
    int nd = c[5] ? 7 : 8;
    v[0] = 1'b0;
    for (int i = 0; i < nd; i++) v[1+i] = d[i];
    if (c[6] || c[7]) v[1+nd] = par_of(d, c);
    return v;
  endfunction

  // transmit one byte with loopback; c_alt is applied during the frame
  task automatic tx_frame(input logic [7:0] d, input logic [7:0] c, input logic [7:0] c_alt);
    int per = per_of(c);
    int len = len_of(c);
    int n0 = n_rx;
    logic [10:0] exp = frame_of(d, c);
    logic [10:0] got = '1;
    logic [7:0] exp_d = c[5] ? {1'b0, d[6:0]} : d;
    logic exp_p = (c[6] || c[7]) ? par_of(d, c) : 1'b0;
    @(negedge clk);
    cfg = c; tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data = ~d;                                   // R6: ignored after capture
    chk(tx_oe == 1'b1, "R3", "start bit driven low", tx_oe, 1);
    chk(tx_ready == 1'b0, "R6", "ready low after accept", tx_ready, 0);
    repeat (per/2) @(negedge clk);
    got[0] = ~tx_oe;
    cfg = c_alt;                                    // R7: mid-frame change
    for (int i = 1; i < len; i++) begin
      repeat (per) @(negedge clk);
      got[i] = ~tx_oe;
    end
    chk(got == exp, "R3", "frame bits", int'(got), int'(exp));
    repeat (per/2 - 1) @(negedge clk);
    chk(tx_ready == 1'b0, "R2", "busy until last tick", tx_ready, 0);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R2", "ready after len*per", tx_ready, 1);
    chk(tx_oe == 1'b0, "R5", "line released when idle", tx_oe, 0);
    repeat (4) @(negedge clk);
    chk(n_rx == n0 + 1, "R8", "one byte received", n_rx - n0, 1);
    if (c[5]) chk(last_d == exp_d, "R10", "7-bit data", last_d, exp_d);
    else      chk(last_d == exp_d, "R8", "8-bit data", last_d, exp_d);
    chk(last_p == exp_p, "R11", "received parity bit", last_p, exp_p);
    chk(rx_perr == 1'b0, "R4", "no parity error", rx_perr, 0);
  endtask

  task automatic send_rx(input logic [10:0] v, input int len, input int per);
    for (int i = 0; i < len; i++) begin
      rx_drv = v[i];
      repeat (per) @(negedge clk);
    end
    rx_drv = 1'b1;
    repeat (2*per) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_oe == 1'b0, "R1", "tx_oe after reset", tx_oe, 0);
    chk(tx_ready == 1'b1, "R1", "tx_ready after reset", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
    chk(rx_perr == 1'b0, "R1", "rx_perr after reset", rx_perr, 0);

    // sweep every rate, width and parity setting (both parity bits included)
    loop = 1'b1;
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 4; p++) begin
          logic [7:0] c = {p[1], p[0], s[0], 3'b000, b[1:0]};
          logic [7:0] d = 8'hA5 ^ 8'(b*59 + s*17 + p*101);
          tx_frame(d, c, c);
          if (b == 3) begin
            tx_frame(8'h00, c, c);
            tx_frame(8'hFF, c, c);
          end
        end

    // R7: config changes mid-frame, both directions keep the captured format
    tx_frame(8'h5A, 8'h43, 8'hA1);
    tx_frame(8'hC3, 8'hA2, 8'h40);

    // R12: no tick, no progress
    loop = 1'b0;
    tick = 1'b0;
    @(negedge clk);
    cfg = 8'h03; tx_data = 8'h96; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk(tx_oe == 1'b1, "R12", "start bit held without tick", tx_oe, 1);
    chk(tx_ready == 1'b0, "R12", "busy held without tick", tx_ready, 0);
    tick = 1'b1;
    repeat (79) @(negedge clk);
    chk(tx_ready == 1'b0, "R12", "full frame still pending", tx_ready, 0);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R12", "frame ends 80 ticks after resume", tx_ready, 1);

    // R9: short low pulses are not starts
    n0 = n_rx;
    cfg = 8'h03;
    rx_drv = 1'b0; repeat (2) @(negedge clk); rx_drv = 1'b1;
    repeat (100) @(negedge clk);
    chk(n_rx == n0, "R9", "glitch at rate 3 ignored", n_rx - n0, 0);
    cfg = 8'h00;
    rx_drv = 1'b0; repeat (30) @(negedge clk); rx_drv = 1'b1;
    repeat (1500) @(negedge clk);
    chk(n_rx == n0, "R9", "glitch at rate 0 ignored", n_rx - n0, 0);

    // R11: wrong parity sets the sticky flag; even sense, 8 bits, data 0x01 needs parity 1
    cfg = 8'h43;
    n0 = n_rx;
    send_rx({1'b1, 1'b0, 8'h01, 1'b0}, 11, 8);
    chk(n_rx == n0 + 1, "R8", "errored byte delivered", n_rx - n0, 1);
    chk(last_d == 8'h01, "R11", "errored byte data", last_d, 8'h01);
    chk(last_p == 1'b0, "R11", "errored parity bit", last_p, 0);
    chk(rx_perr == 1'b1, "R11", "parity error flagged", rx_perr, 1);
    send_rx({1'b1, 1'b0, 8'h03, 1'b0}, 11, 8);
    chk(last_d == 8'h03, "R8", "good byte after error", last_d, 8'h03);
    chk(rx_perr == 1'b1, "R11", "error flag sticky", rx_perr, 1);

    // R4/R10: 7-bit odd, parity in bit position 7; data 0x15 has 3 ones so odd parity bit is 0
    cfg = 8'hA3;
    send_rx({1'b1, 1'b0, 7'h15, 1'b0}, 10, 8);
    chk(last_d == 8'h15, "R10", "7-bit odd data", last_d, 8'h15);
    chk(last_p == 1'b0, "R4", "7-bit odd parity bit", last_p, 0);

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_perr == 1'b0, "R11", "reset clears error", rx_perr, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule